// File: doc/BRIEF.md
# Packed Shuffle and Logical Unit

This block rearranges and combines packed data on a 64-bit datapath. A direct issue port accepts one operation per cycle. Each operation has an opcode, two 64-bit sources and an 8-bit immediate. The operation set is a register move, four bitwise logical operations, interleaving of the low or high halves of two sources, a 16-bit word permute, a 16-bit word insert, a 16-bit word extract, and the two half-steps of a single-precision element shuffle. Every operation returns one 64-bit result a fixed number of cycles later.

A 128-bit single-precision shuffle is wider than the datapath, so a small sequencer splits it into three ordered micro-operations:

1. It copies the destination register into a temporary.
2. It builds the low 64 bits of the result through the shared datapath.
3. It builds the high 64 bits of the result through the shared datapath.

The destination register is updated in place. When the second source is the destination itself, the high step reads that register's original contents from the temporary, not from the half already overwritten. While the sequence runs, the unit reports busy and ignores new work from either port.

Top module: `lane_permute_unit`

## Requirements
- R1: An operation offered on `op_valid` while `busy` is low is captured at that clock edge. Its result appears on `res_data`, with `res_valid` high for exactly one cycle, after `LAT` rising edges counted from the capture edge. No other edge raises `res_valid`.
- R2: Opcode values 0 to 4 are: move (result = b), AND (a & b), and-not (~a & b), OR (a | b) and XOR (a ^ b). Opcode values 12 to 15 are unused and return zero.
- R3: Opcode 5 interleaves the low 32 bits of a and b, and opcode 6 interleaves the upper 32 bits. The element width comes from imm[1:0]: 0 selects 8-bit elements, 1 selects 16-bit elements, and 2 or 3 selects 32-bit elements. Result element 2k is element k of a, and result element 2k+1 is element k of b.
- R4: Opcode 7 is the word permute. 16-bit lane i of the result (lane 0 = bits 15:0) equals lane imm[2i+1:2i] of a.
- R5: Opcode 8 returns a with lane imm[1:0] replaced by b[15:0].
- R6: Opcode 9 returns lane imm[1:0] of a in bits 15:0, with all higher bits zero.
- R7: Opcodes 10 and 11 treat a as 32-bit elements 0 and 1 and b as elements 2 and 3. Opcode 10 places element imm[1:0] in bits 31:0 and element imm[3:2] in bits 63:32. Opcode 11 does the same with imm[5:4] and imm[7:6].
- R8: A 128-bit shuffle request is accepted when `shuf_req` is high and `busy` is low. `shuf_result` then holds these four 32-bit elements, lowest first:
  - element imm[1:0] of `shuf_dst`;
  - element imm[3:2] of `shuf_dst`;
  - element imm[5:4] of the second source;
  - element imm[7:6] of the second source.
  `shuf_done` pulses for one cycle to mark the result valid.
- R9: The sequencer runs three micro-operations in a fixed order: the copy to the temporary, then the low half, then the high half.
- R10: With `shuf_alias` high, the second source is the destination register itself and `shuf_src` is ignored. The result equals the shuffle of `shuf_dst` with itself.
- R11: `busy` is high from the edge that accepts a shuffle until the edge that raises `shuf_done`. While `busy` is high, `shuf_req` and `op_valid` are ignored: they produce no result and no extra `shuf_done`, and they leave the pending result unchanged.
- R12: After reset, `res_valid`, `busy` and `shuf_done` are low, and `shuf_result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Direct operation offered |
| op_code | input | 4 | Direct operation code |
| op_a | input | 64 | First source |
| op_b | input | 64 | Second source |
| op_imm | input | 8 | Immediate |
| res_valid | output | 1 | Direct result valid |
| res_data | output | 64 | Direct result |
| shuf_req | input | 1 | 128-bit shuffle request |
| shuf_dst | input | 128 | Destination register (also first source) |
| shuf_src | input | 128 | Second source register |
| shuf_imm | input | 8 | Element selectors for the shuffle |
| shuf_alias | input | 1 | Second source is the destination register |
| busy | output | 1 | Sequencer active |
| shuf_done | output | 1 | Shuffle result valid pulse |
| shuf_result | output | 128 | Updated destination register |

## Verification
A wrong temporary or a bad step ordering corrupts only the upper 64 bits of `shuf_result`, and only when the shuffle is aliased. The aliased random shuffles therefore compare all 128 bits the cycle `shuf_done` rises. A sequencer stuck in a state shows as `busy` that never falls, which the bounded done-wait catches within a few dozen cycles. A micro-operation result that leaks to the direct port shows as a stray `res_valid`, which is watched on every cycle of a busy window.

// File: rtl/lpu_pkg.sv
package lpu_pkg;
  localparam int DW      = 64;
  localparam int LANE_W  = 16;
  localparam int N_LANES = DW / LANE_W;
  localparam int ELEM_W  = 32;
  localparam int IMM_W   = 8;
  localparam int OPC_W   = 4;
  localparam int WIDE_W  = 2 * DW;

  typedef enum logic [OPC_W-1:0] {
    OP_MOVE     = 4'd0,
    OP_AND      = 4'd1,
    OP_ANDN     = 4'd2,
    OP_OR       = 4'd3,
    OP_XOR      = 4'd4,
    OP_UNPK_LO  = 4'd5,
    OP_UNPK_HI  = 4'd6,
    OP_WPERM    = 4'd7,
    OP_WINS     = 4'd8,
    OP_WEXT     = 4'd9,
    OP_FSHUF_LO = 4'd10,
    OP_FSHUF_HI = 4'd11
  } lpu_op_e;

  // 16-bit lane pick
  function automatic logic [LANE_W-1:0] f_lane16(logic [DW-1:0] v, logic [1:0] sel);
    return v[{sel, 4'b0000} +: LANE_W];
  endfunction

  // 32-bit element pick from the pair {hi, lo}
  function automatic logic [ELEM_W-1:0] f_sel32(logic [DW-1:0] lo, logic [DW-1:0] hi,
                                                logic [1:0] sel);
    logic [ELEM_W-1:0] r;
    case (sel)
      2'd0:    r = lo[31:0];
      2'd1:    r = lo[63:32];
      2'd2:    r = hi[31:0];
      default: r = hi[63:32];
    endcase
    return r;
  endfunction

  // R3: interleave of lower or upper 32-bit halves, element size by esz
  function automatic logic [DW-1:0] f_unpack(logic [DW-1:0] a, logic [DW-1:0] b,
                                             logic upper, logic [1:0] esz);
    logic [31:0] ha, hb;
    logic [DW-1:0] r;
    ha = upper ? a[63:32] : a[31:0];
    hb = upper ? b[63:32] : b[31:0];
    r  = '0;
    case (esz)
      2'd0: begin
        for (int i = 0; i < 4; i++) begin
          r[16*i +: 8]     = ha[8*i +: 8];
          r[16*i + 8 +: 8] = hb[8*i +: 8];
        end
      end
      2'd1: begin
        for (int i = 0; i < 2; i++) begin
          r[32*i +: 16]      = ha[16*i +: 16];
          r[32*i + 16 +: 16] = hb[16*i +: 16];
        end
      end
      default: r = {hb, ha};
    endcase
    return r;
  endfunction

  // R5: insert a word into the lane named by sel
  function automatic logic [DW-1:0] f_winsert(logic [DW-1:0] a, logic [LANE_W-1:0] w,
                                              logic [1:0] sel);
    logic [DW-1:0] r;
    r = a;
    r[{sel, 4'b0000} +: LANE_W] = w;
    return r;
  endfunction

  // R2: logical group
  function automatic logic [DW-1:0] f_logic(lpu_op_e op, logic [DW-1:0] a, logic [DW-1:0] b);
    logic [DW-1:0] r;
    case (op)
      OP_MOVE: r = b;
      OP_AND:  r = a & b;
      OP_ANDN: r = ~a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/lpu_exec.sv
module lpu_exec
  import lpu_pkg::*;
(
  input  lpu_op_e          op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  logic [IMM_W-1:0] imm,
  output logic [DW-1:0]    res
);
  logic [DW-1:0] wperm_r;

  // R4: one selector per lane
  genvar ln;
  generate
    for (ln = 0; ln < N_LANES; ln++) begin : g_wperm
      assign wperm_r[LANE_W*ln +: LANE_W] = f_lane16(a, imm[2*ln +: 2]);
    end
  endgenerate

  always_comb begin
    case (op)
      OP_MOVE, OP_AND, OP_ANDN, OP_OR, OP_XOR:
        res = f_logic(op, a, b);
      OP_UNPK_LO:  res = f_unpack(a, b, 1'b0, imm[1:0]);
      OP_UNPK_HI:  res = f_unpack(a, b, 1'b1, imm[1:0]);
      OP_WPERM:    res = wperm_r;
      OP_WINS:     res = f_winsert(a, b[LANE_W-1:0], imm[1:0]);
      OP_WEXT:     res = {{(DW-LANE_W){1'b0}}, f_lane16(a, imm[1:0])};
      OP_FSHUF_LO: res = {f_sel32(a, b, imm[3:2]), f_sel32(a, b, imm[1:0])};
      OP_FSHUF_HI: res = {f_sel32(a, b, imm[7:6]), f_sel32(a, b, imm[5:4])};
      default:     res = '0;
    endcase
  end
endmodule

// File: rtl/lpu_pipe.sv
module lpu_pipe
  import lpu_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_seq,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic          out_seq,
  output logic [DW-1:0] out_data
);
  logic [LAT-1:0] v_q;
  logic [LAT-1:0] s_q;
  logic [DW-1:0]  d_q [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      s_q <= '0;
    end else begin
      v_q[0] <= in_valid;
      s_q[0] <= in_seq;
      for (int s = 1; s < LAT; s++) begin
        v_q[s] <= v_q[s-1];
        s_q[s] <= s_q[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    d_q[0] <= in_data;
    for (int s = 1; s < LAT; s++) d_q[s] <= d_q[s-1];
  end

  assign out_valid = v_q[LAT-1];
  assign out_seq   = s_q[LAT-1];
  assign out_data  = d_q[LAT-1];
endmodule

// File: rtl/lpu_seq.sv
module lpu_seq
  import lpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [WIDE_W-1:0] dst,
  input  logic [WIDE_W-1:0] src,
  input  logic [IMM_W-1:0] imm,
  input  logic             alias_in,
  input  logic             uop_res_valid,
  input  logic [DW-1:0]    uop_res_data,
  output logic             busy,
  output logic             done,
  output logic [WIDE_W-1:0] result,
  output logic             issue_valid,
  output lpu_op_e          issue_op,
  output logic [DW-1:0]    issue_a,
  output logic [DW-1:0]    issue_b,
  output logic [IMM_W-1:0] issue_imm,
  output logic             copy_ev,
  output logic             lo_ev,
  output logic             hi_ev
);
  typedef enum logic [2:0] {
    S_IDLE, S_COPY, S_LO_ISS, S_LO_WAIT, S_HI_ISS, S_HI_WAIT
  } seq_st_e;

  seq_st_e            st_q;
  logic [WIDE_W-1:0]  dreg_q;   // destination register, updated in place
  logic [WIDE_W-1:0]  src_q;
  logic [WIDE_W-1:0]  tmp_q;
  logic [IMM_W-1:0]   imm_q;
  logic               alias_q;
  logic               done_q;
  logic [WIDE_W-1:0]  hi_src;

  assign copy_ev = (st_q == S_COPY);
  assign lo_ev   = (st_q == S_LO_ISS);
  assign hi_ev   = (st_q == S_HI_ISS);
  assign busy    = (st_q != S_IDLE);
  assign done    = done_q;
  assign result  = dreg_q;

  // R10: an aliased second source is the destination before its update
  assign hi_src = alias_q ? tmp_q : src_q;

  always_comb begin
    issue_valid = lo_ev | hi_ev;
    issue_op    = hi_ev ? OP_FSHUF_HI : OP_FSHUF_LO;
    issue_a     = hi_ev ? hi_src[DW-1:0]      : tmp_q[DW-1:0];
    issue_b     = hi_ev ? hi_src[WIDE_W-1:DW] : tmp_q[WIDE_W-1:DW];
    issue_imm   = imm_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      dreg_q  <= '0;
      src_q   <= '0;
      tmp_q   <= '0;
      imm_q   <= '0;
      alias_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (req) begin
          dreg_q  <= dst;
          src_q   <= src;
          imm_q   <= imm;
          alias_q <= alias_in;
          st_q    <= S_COPY;
        end
        S_COPY: begin
          tmp_q <= dreg_q;
          st_q  <= S_LO_ISS;
        end
        S_LO_ISS: st_q <= S_LO_WAIT;
        S_LO_WAIT: if (uop_res_valid) begin
          dreg_q[DW-1:0] <= uop_res_data;
          st_q           <= S_HI_ISS;
        end
        S_HI_ISS: st_q <= S_HI_WAIT;
        S_HI_WAIT: if (uop_res_valid) begin
          dreg_q[WIDE_W-1:DW] <= uop_res_data;
          done_q              <= 1'b1;
          st_q                <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
  import lpu_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [OPC_W-1:0]   op_code,
  input  logic [DW-1:0]      op_a,
  input  logic [DW-1:0]      op_b,
  input  logic [IMM_W-1:0]   op_imm,
  output logic               res_valid,
  output logic [DW-1:0]      res_data,
  input  logic               shuf_req,
  input  logic [WIDE_W-1:0]  shuf_dst,
  input  logic [WIDE_W-1:0]  shuf_src,
  input  logic [IMM_W-1:0]   shuf_imm,
  input  logic               shuf_alias,
  output logic               busy,
  output logic               shuf_done,
  output logic [WIDE_W-1:0]  shuf_result
);
  logic            ext_accept;
  logic            seq_issue;
  lpu_op_e         seq_op;
  logic [DW-1:0]   seq_a, seq_b;
  logic [IMM_W-1:0] seq_imm;
  logic            copy_ev, lo_ev, hi_ev;
  lpu_op_e         x_op;
  logic [DW-1:0]   x_a, x_b, x_res;
  logic [IMM_W-1:0] x_imm;
  logic            pipe_valid, pipe_seq;
  logic [DW-1:0]   pipe_data;
  logic            uop_back;

  assign ext_accept = op_valid & ~busy;     // R11
  assign uop_back   = pipe_valid & pipe_seq;

  lpu_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req           (shuf_req),
    .dst           (shuf_dst),
    .src           (shuf_src),
    .imm           (shuf_imm),
    .alias_in      (shuf_alias),
    .uop_res_valid (uop_back),
    .uop_res_data  (pipe_data),
    .busy          (busy),
    .done          (shuf_done),
    .result        (shuf_result),
    .issue_valid   (seq_issue),
    .issue_op      (seq_op),
    .issue_a       (seq_a),
    .issue_b       (seq_b),
    .issue_imm     (seq_imm),
    .copy_ev       (copy_ev),
    .lo_ev         (lo_ev),
    .hi_ev         (hi_ev)
  );

  always_comb begin
    if (seq_issue) begin
      x_op = seq_op; x_a = seq_a; x_b = seq_b; x_imm = seq_imm;
    end else begin
      x_op = lpu_op_e'(op_code); x_a = op_a; x_b = op_b; x_imm = op_imm;
    end
  end

  lpu_exec u_exec (
    .op  (x_op),
    .a   (x_a),
    .b   (x_b),
    .imm (x_imm),
    .res (x_res)
  );

  lpu_pipe #(.LAT(LAT)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (seq_issue | ext_accept),
    .in_seq    (seq_issue),
    .in_data   (x_res),
    .out_valid (pipe_valid),
    .out_seq   (pipe_seq),
    .out_data  (pipe_data)
  );

  assign res_valid = pipe_valid & ~pipe_seq;
  assign res_data  = res_valid ? pipe_data : '0;
endmodule

// File: rtl/lane_permute_unit_chk.sv
module lane_permute_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic shuf_req,
  input logic busy,
  input logic shuf_done,
  input logic res_valid,
  input logic copy_ev,
  input logic lo_ev,
  input logic hi_ev,
  input logic uop_back
);
  logic lo_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         lo_seen_q <= 1'b0;
    else if (lo_ev)     lo_seen_q <= 1'b1;
    else if (shuf_done) lo_seen_q <= 1'b0;
  end

  a_r9_copy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (shuf_req && !busy) |=> copy_ev);
  a_r9_lo_after_copy: assert property (@(posedge clk) disable iff (!rst_n)
    copy_ev |=> lo_ev);
  a_r9_hi_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
    hi_ev |-> lo_seen_q);
  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (shuf_req && !busy) |=> busy);
  a_r11_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    shuf_done |-> !busy);
  a_r1_uop_not_visible: assert property (@(posedge clk) disable iff (!rst_n)
    uop_back |-> !res_valid);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    shuf_done |=> !shuf_done);
endmodule

bind lane_permute_unit lane_permute_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .shuf_req  (shuf_req),
  .busy      (busy),
  .shuf_done (shuf_done),
  .res_valid (res_valid),
  .copy_ev   (copy_ev),
  .lo_ev     (lo_ev),
  .hi_ev     (hi_ev),
  .uop_back  (uop_back)
);

// File: tb/lane_permute_unit_bench.sv
module lane_permute_unit_bench;
  localparam int LAT = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic [3:0]   op_code = '0;
  logic [63:0]  op_a = '0, op_b = '0;
  logic [7:0]   op_imm = '0;
  logic         res_valid;
  logic [63:0]  res_data;
  logic         shuf_req = 1'b0;
  logic [127:0] shuf_dst = '0, shuf_src = '0;
  logic [7:0]   shuf_imm = '0;
  logic         shuf_alias = 1'b0;
  logic         busy, shuf_done;
  logic [127:0] shuf_result;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lane_permute_unit #(.LAT(LAT)) u_lane_permute_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .op_imm(op_imm), .res_valid(res_valid),
    .res_data(res_data), .shuf_req(shuf_req), .shuf_dst(shuf_dst),
    .shuf_src(shuf_src), .shuf_imm(shuf_imm), .shuf_alias(shuf_alias),
    .busy(busy), .shuf_done(shuf_done), .shuf_result(shuf_result)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---- bench models ----
  function automatic logic [63:0] m_unpack(logic [63:0] a, logic [63:0] b, bit hi,
                                           logic [1:0] esz);
    int w; logic [63:0] sa, sb, m, r;
    w  = (esz == 2'd0) ? 8 : (esz == 2'd1) ? 16 : 32;
    sa = hi ? (a >> 32) : a;
    sb = hi ? (b >> 32) : b;
    m  = (64'd1 << w) - 64'd1;
    r  = '0;
    for (int k = 0; k < 32 / w; k++) begin
      r |= ((sa >> (k * w)) & m) << (2 * k * w);
      r |= ((sb >> (k * w)) & m) << ((2 * k + 1) * w);
    end
    return r;
  endfunction

  function automatic logic [15:0] m_word(logic [63:0] v, int idx);
    return 16'((v >> (16 * idx)) & 64'hFFFF);
  endfunction

  function automatic logic [31:0] m_elem(logic [127:0] v, int idx);
    return 32'((v >> (32 * idx)) & 128'hFFFF_FFFF);
  endfunction

  function automatic logic [63:0] m_op(logic [3:0] c, logic [63:0] a, logic [63:0] b,
                                       logic [7:0] imm);
    logic [63:0] r; logic [127:0] ab;
    ab = {b, a};
    r  = '0;
    case (c)
      4'd0: r = b;
      4'd1: r = a & b;
      4'd2: r = b & ~a;
      4'd3: r = a | b;
      4'd4: r = a ^ b;
      4'd5: r = m_unpack(a, b, 1'b0, imm[1:0]);
      4'd6: r = m_unpack(a, b, 1'b1, imm[1:0]);
      4'd7: for (int i = 0; i < 4; i++)
              r |= 64'(m_word(a, int'((imm >> (2 * i)) & 8'd3))) << (16 * i);
      4'd8: begin
        r = a & ~(64'hFFFF << (16 * imm[1:0]));
        r |= 64'(b[15:0]) << (16 * imm[1:0]);
      end
      4'd9: r = 64'(m_word(a, int'(imm[1:0])));
      4'd10: r = {m_elem(ab, int'(imm[3:2])), m_elem(ab, int'(imm[1:0]))};
      4'd11: r = {m_elem(ab, int'(imm[7:6])), m_elem(ab, int'(imm[5:4]))};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [127:0] m_shuf(logic [127:0] x, logic [127:0] y, logic [7:0] imm);
    return {m_elem(y, int'(imm[7:6])), m_elem(y, int'(imm[5:4])),
            m_elem(x, int'(imm[3:2])), m_elem(x, int'(imm[1:0]))};
  endfunction

  function automatic string tag_of(logic [3:0] c);
    case (c)
      4'd5, 4'd6:   return "R3";
      4'd7:         return "R4";
      4'd8:         return "R5";
      4'd9:         return "R6";
      4'd10, 4'd11: return "R7";
      default:      return "R2";
    endcase
  endfunction

  // ---- stimulus tasks ----
  task automatic run_op(input logic [3:0] c, input logic [63:0] a, input logic [63:0] b,
                        input logic [7:0] imm);
    logic [63:0] e;
    e = m_op(c, a, b, imm);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; op_a = a; op_b = b; op_imm = imm;
    @(negedge clk);
    op_valid = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    chk(res_valid === 1'b1, "R1 res_valid", 128'(res_valid), 128'd1);
    chk(res_data === e, tag_of(c), 128'(res_data), 128'(e));
  endtask

  task automatic run_shuf(input logic [127:0] x, input logic [127:0] y,
                          input logic [7:0] imm, input bit al);
    logic [127:0] e;
    int n;
    e = m_shuf(x, al ? x : y, imm);
    @(negedge clk);
    shuf_req = 1'b1; shuf_dst = x; shuf_src = y; shuf_imm = imm; shuf_alias = al;
    @(negedge clk);
    shuf_req = 1'b0;
    chk(busy === 1'b1, "R11 busy after accept", 128'(busy), 128'd1);
    n = 0;
    while (!shuf_done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(shuf_done === 1'b1, "R8 done", 128'(shuf_done), 128'd1);
    chk(shuf_result === e, al ? "R10 alias result" : "R8 result", shuf_result, e);
    @(negedge clk);
    chk(shuf_done === 1'b0 && busy === 1'b0, "R11 done single, busy cleared",
        128'({shuf_done, busy}), 128'd0);
  endtask

  // ---- watchdog ----
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---- main ----
  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(res_valid === 1'b0 && busy === 1'b0 && shuf_done === 1'b0,
        "R12 reset flags", 128'({res_valid, busy, shuf_done}), 128'd0);
    chk(shuf_result === 128'd0, "R12 reset result", shuf_result, 128'd0);
    rst_n = 1'b1;

    // R1 exact latency: no result one edge after capture
    @(negedge clk);
    op_valid = 1'b1; op_code = 4'd4; op_a = 64'hF0F0; op_b = 64'h0FF0; op_imm = '0;
    @(negedge clk);
    op_valid = 1'b0;
    if (LAT > 1)
      chk(res_valid === 1'b0, "R1 not early", 128'(res_valid), 128'd0);
    repeat (LAT - 1) @(negedge clk);
    chk(res_valid === 1'b1 && res_data === 64'hFF00, "R1 on time",
        128'(res_data), 128'hFF00);
    @(negedge clk);
    chk(res_valid === 1'b0, "R1 single pulse", 128'(res_valid), 128'd0);

    // directed corners
    run_op(4'd2, 64'hFFFF_0000_FFFF_0000, 64'h1234_5678_9ABC_DEF0, 8'h00); // R2 andn
    run_op(4'd13, 64'hFFFF, 64'hFFFF, 8'hFF);                              // R2 unused
    for (int esz = 0; esz < 4; esz++) begin                               // R3 widths
      run_op(4'd5, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9988, 8'(esz));
      run_op(4'd6, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9988, 8'(esz));
    end
    run_op(4'd7, 64'h4444_3333_2222_1111, '0, 8'h1B);                      // R4 reverse
    for (int ln = 0; ln < 4; ln++)                                         // R5 each lane
      run_op(4'd8, 64'hAAAA_BBBB_CCCC_DDDD, 64'h0000_0000_0000_1234, 8'(ln));
    run_op(4'd9, 64'hFEDC_0000_0000_0000, '0, 8'h03);                      // R6 top lane
    run_op(4'd10, 64'h2222_2222_1111_1111, 64'h4444_4444_3333_3333, 8'hE4); // R7
    run_op(4'd11, 64'h2222_2222_1111_1111, 64'h4444_4444_3333_3333, 8'h1B); // R7

    // random direct ops
    for (int i = 0; i < 300; i++)
      run_op(4'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, 8'($urandom));

    // R10 directed alias, R8 directed non-alias
    run_shuf(128'h4444_4444_3333_3333_2222_2222_1111_1111,
             128'h8888_8888_7777_7777_6666_6666_5555_5555, 8'hB1, 1'b0);
    run_shuf(128'h4444_4444_3333_3333_2222_2222_1111_1111,
             128'hDEAD_BEEF_DEAD_BEEF_DEAD_BEEF_DEAD_BEEF, 8'h50, 1'b1);
    run_shuf(128'h4444_4444_3333_3333_2222_2222_1111_1111, '0, 8'h1B, 1'b1);

    // random shuffles
    for (int i = 0; i < 80; i++)
      run_shuf({$urandom, $urandom, $urandom, $urandom},
               {$urandom, $urandom, $urandom, $urandom}, 8'($urandom), 1'($urandom));

    // R11: work offered while busy is ignored
    begin
      logic [127:0] xa, ya, e;
      int n;
      bit stray;
      xa = 128'h0D0D_0D0D_0C0C_0C0C_0B0B_0B0B_0A0A_0A0A;
      ya = 128'h1D1D_1D1D_1C1C_1C1C_1B1B_1B1B_1A1A_1A1A;
      e  = m_shuf(xa, ya, 8'h4E);
      stray = 1'b0;
      @(negedge clk);
      shuf_req = 1'b1; shuf_dst = xa; shuf_src = ya; shuf_imm = 8'h4E; shuf_alias = 1'b0;
      @(negedge clk);
      shuf_dst = ~xa; shuf_src = ~ya; shuf_imm = 8'hFF;
      op_valid = 1'b1; op_code = 4'd3; op_a = '1; op_b = '1;
      n = 0;
      while (!shuf_done && n < 40) begin
        if (n == 3) begin shuf_req = 1'b0; op_valid = 1'b0; end
        if (res_valid) stray = 1'b1;
        @(negedge clk);
        n++;
      end
      shuf_req = 1'b0; op_valid = 1'b0;
      chk(stray == 1'b0, "R11 no direct result while busy", 128'(stray), 128'd0);
      chk(shuf_result === e, "R11 pending result kept", shuf_result, e);
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (shuf_done || res_valid || busy) stray = 1'b1;
      end
      chk(stray == 1'b0, "R11 no late done or result", 128'(stray), 128'd0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule